// File: doc/BRIEF.md
# Auto-Negotiation Expansion Status Register

This block holds the expansion status word that a management agent reads to learn how auto-negotiation with the remote station is progressing. The auto-negotiation engine feeds it single-cycle events: a fault when the partner's technology could not be identified, a strobe each time a link code word from the partner has been stored (carrying that word's Next Page bit), a level or pulse showing that valid fast link pulse bursts are arriving, and a restart or link-loss indication.

Two of the bits are sticky. Once an event sets them, they stay set until software reads the register, so a short event is never missed between polls. A read clears them on the same clock edge that captures the read data. An event that arrives in the same cycle as that read wins: the read reports the old value, and the bit stays set for the next read. Two further bits follow the partner's state and clear on restart or link loss. One bit is a constant that advertises local Next Page support. The register has no write port.

Top module: `aneg_xp_status`

## Requirements
- R1: Bit 4 (parallel-detection fault) goes to one on the edge after `pd_fault_i` is high and stays one until it is cleared by a matching read.
- R2: Bit 1 (page received) goes to one on the edge after `cw_stored_i` is high and stays one until it is cleared by a matching read.
- R3: A matching read (`rd_en_i` high and `rd_addr_i` equal to `REG_ADDR`, default 6) clears bits 4 and 1 on the same edge that captures the read data. The data returned shows the values from before the clear.
- R4: If the set event for bit 4 or bit 1 occurs in the same cycle as a matching read, the read returns the old bit value and the bit is one afterwards.
- R5: Bit 3 (partner Next Page) takes the value of `cw_np_i` on every edge where `cw_stored_i` is high. It may go to zero as well as to one, and it holds otherwise.
- R6: Bit 0 (partner auto-negotiation able) reads zero until `flp_ok_i` is seen high. After that it stays one.
- R7: `an_reset_i` clears bits 0 and 3 on the next edge, even if there is a set event for either bit in the same cycle. It leaves bits 4 and 1 unchanged.
- R8: Bit 2 always reads as `LOCAL_NP` (default 1), and bits 15 to 5 always read as zero.
- R9: `rd_data_o` is registered. In the cycle after a matching read strobe it holds the status word as it was before that edge. In every other cycle it is zero.
- R10: A read strobe at any other address clears nothing, and the cycle after it `rd_data_o` is zero.
- R11: A synchronous high `rst` clears bits 0, 1, 3 and 4 and `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_fault_i | input | 1 | Parallel-detection fault event |
| cw_stored_i | input | 1 | Partner link code word stored this cycle |
| cw_np_i | input | 1 | Next Page bit of the stored code word |
| flp_ok_i | input | 1 | Valid fast link pulse bursts seen from partner |
| an_reset_i | input | 1 | Auto-negotiation restart or link loss |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Register address of the read |
| rd_data_o | output | 16 | Registered read data |

## Verification
The bench builds the block with `ADDR_W` = 5, `REG_ADDR` = 6 and `LOCAL_NP` = 1. With these values, reads at the matching address and reads at other addresses can be mixed freely in the 5-bit space. The constant bit 2 is visible as a one in every returned word, so a read with all other bits zero can still be told apart from the idle zero. These settings let the bench line up every kind of collision: a fault or page event in the same cycle as a clearing read, and a restart in the same cycle as a code-word store or burst indication. It then confirms the outcome on the following reads.

// File: rtl/aneg_xp_pkg.sv
package aneg_xp_pkg;

    localparam int REG_W     = 16;
    localparam int FAULT_BIT = 4;
    localparam int LPNP_BIT  = 3;
    localparam int LNP_BIT   = 2;
    localparam int PAGE_BIT  = 1;
    localparam int LPAN_BIT  = 0;
    localparam int USED_W    = FAULT_BIT + 1;

    // sticky bits, one index each in the latch vector
    localparam int STICKY_N    = 2;
    localparam int STICKY_PAGE = 0;
    localparam int STICKY_FLT  = 1;

    typedef logic [REG_W-1:0] xp_word_t;

    typedef struct packed {
        logic fault;
        logic page;
    } xp_sticky_t;

    typedef struct packed {
        logic np;
        logic an;
    } xp_partner_t;

    function automatic xp_word_t xp_pack(xp_sticky_t s, xp_partner_t p, logic lnp);
        xp_word_t w;
        w            = '0;
        w[FAULT_BIT] = s.fault;
        w[LPNP_BIT]  = p.np;
        w[LNP_BIT]   = lnp;
        w[PAGE_BIT]  = s.page;
        w[LPAN_BIT]  = p.an;
        return w;
    endfunction

endpackage

// File: rtl/aneg_xp_sticky.sv
module aneg_xp_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] q_o
);

    // a set in the clearing cycle takes priority, so no event is dropped
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i)
                q_o[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/aneg_xp_partner.sv
module aneg_xp_partner
    import aneg_xp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cw_stored_i,
    input  logic        cw_np_i,
    input  logic        flp_ok_i,
    input  logic        an_reset_i,
    output xp_partner_t st_o
);

    always_ff @(posedge clk) begin
        if (rst || an_reset_i) begin
            st_o <= '0;
        end else begin
            if (cw_stored_i)
                st_o.np <= cw_np_i;
            if (flp_ok_i)
                st_o.an <= 1'b1;
        end
    end

endmodule

// File: rtl/aneg_xp_rdport.sv
module aneg_xp_rdport
    import aneg_xp_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  xp_word_t          word_i,
    output logic              hit_o,
    output xp_word_t          rd_data_o
);

    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    assign hit_o = rd_en_i && (rd_addr_i == MATCH);

    always_ff @(posedge clk) begin
        if (rst)
            rd_data_o <= '0;
        else if (hit_o)
            rd_data_o <= word_i;
        else
            rd_data_o <= '0;
    end

endmodule

// File: rtl/aneg_xp_status.sv
module aneg_xp_status
    import aneg_xp_pkg::*;
#(
    parameter int   ADDR_W   = 5,
    parameter int   REG_ADDR = 6,
    parameter logic LOCAL_NP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_fault_i,
    input  logic              cw_stored_i,
    input  logic              cw_np_i,
    input  logic              flp_ok_i,
    input  logic              an_reset_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [15:0]       rd_data_o
);

    logic [STICKY_N-1:0] sticky_set;
    logic [STICKY_N-1:0] sticky_q;
    logic                rd_hit;
    xp_sticky_t          sticky_st;
    xp_partner_t         partner_st;
    xp_word_t            stat_w;
    xp_word_t            rd_word;

    always_comb begin
        sticky_set              = '0;
        sticky_set[STICKY_FLT]  = pd_fault_i;
        sticky_set[STICKY_PAGE] = cw_stored_i;
        sticky_st.fault         = sticky_q[STICKY_FLT];
        sticky_st.page          = sticky_q[STICKY_PAGE];
    end

    aneg_xp_sticky #(.N(STICKY_N)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (sticky_set),
        .clr_i (rd_hit),
        .q_o   (sticky_q)
    );

    aneg_xp_partner u_partner (
        .clk         (clk),
        .rst         (rst),
        .cw_stored_i (cw_stored_i),
        .cw_np_i     (cw_np_i),
        .flp_ok_i    (flp_ok_i),
        .an_reset_i  (an_reset_i),
        .st_o        (partner_st)
    );

    assign stat_w = xp_pack(sticky_st, partner_st, LOCAL_NP);

    aneg_xp_rdport #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .word_i    (stat_w),
        .hit_o     (rd_hit),
        .rd_data_o (rd_word)
    );

    assign rd_data_o = rd_word;

endmodule

// File: rtl/aneg_xp_status_chk.sv
module aneg_xp_status_chk #(
    parameter int   ADDR_W   = 5,
    parameter int   REG_ADDR = 6,
    parameter logic LOCAL_NP = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              pd_fault_i,
    input logic              cw_stored_i,
    input logic              cw_np_i,
    input logic              flp_ok_i,
    input logic              an_reset_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [15:0]       rd_data_o,
    input logic [15:0]       stat_w
);

    logic hit;
    assign hit = rd_en_i && (rd_addr_i == ADDR_W'(REG_ADDR));

    assert_fault_set_R1: assert property (@(posedge clk) disable iff (rst)
        pd_fault_i |=> stat_w[4]);

    assert_page_set_R2: assert property (@(posedge clk) disable iff (rst)
        cw_stored_i |=> stat_w[1]);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && !pd_fault_i && !cw_stored_i) |=> (stat_w[4] == 1'b0 && stat_w[1] == 1'b0));

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!hit && stat_w[4]) |=> stat_w[4]);

    assert_np_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (cw_stored_i && !an_reset_i) |=> stat_w[3] == $past(cw_np_i));

    assert_an_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_w[0] && !an_reset_i) |=> stat_w[0]);

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        an_reset_i |=> (stat_w[0] == 1'b0 && stat_w[3] == 1'b0));

    assert_const_bits_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_w[15:5] == 11'd0 && stat_w[2] == LOCAL_NP));

    assert_rd_capture_R9: assert property (@(posedge clk) disable iff (rst)
        hit |=> rd_data_o == $past(stat_w));

    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !hit |=> rd_data_o == 16'd0);

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (rd_data_o == 16'd0 && stat_w[4:3] == 2'b00 && stat_w[1:0] == 2'b00));

endmodule

bind aneg_xp_status aneg_xp_status_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .LOCAL_NP (LOCAL_NP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_fault_i  (pd_fault_i),
    .cw_stored_i (cw_stored_i),
    .cw_np_i     (cw_np_i),
    .flp_ok_i    (flp_ok_i),
    .an_reset_i  (an_reset_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .stat_w      (stat_w)
);

// File: tb/aneg_xp_status_tb.sv
`timescale 1ns/1ps
module aneg_xp_status_tb;

    localparam int ADDR_W = 5;
    localparam int MY_ADDR = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd = 1'b0, cw = 1'b0, np = 1'b0, flp = 1'b0, ar = 1'b0, rd = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    bit m_flt, m_page, m_np, m_an;
    logic [15:0] exp_rd;

    always #4 clk = ~clk;

    aneg_xp_status #(.ADDR_W(ADDR_W), .REG_ADDR(MY_ADDR), .LOCAL_NP(1'b1)) u_dut (
        .clk (clk), .rst (rst),
        .pd_fault_i (pd), .cw_stored_i (cw), .cw_np_i (np),
        .flp_ok_i (flp), .an_reset_i (ar),
        .rd_en_i (rd), .rd_addr_i (addr), .rd_data_o (rd_data)
    );

    task automatic model_edge();
        bit hit;
        if (rst) begin
            m_flt = 0; m_page = 0; m_np = 0; m_an = 0; exp_rd = 16'h0;
        end else begin
            hit = rd && (addr == ADDR_W'(MY_ADDR));
            exp_rd = hit ? {11'd0, m_flt, m_np, 1'b1, m_page, m_an} : 16'h0;
            if (pd) m_flt = 1; else if (hit) m_flt = 0;
            if (cw) m_page = 1; else if (hit) m_page = 0;
            if (ar) begin
                m_np = 0; m_an = 0;
            end else begin
                if (cw) m_np = np;
                if (flp) m_an = 1;
            end
        end
    endtask

    task automatic cyc(input bit r, input bit p, input bit c, input bit n, input bit f,
                       input bit a, input bit re, input int ad, input string tag);
        rst = r; pd = p; cw = c; np = n; flp = f; ar = a; rd = re; addr = ADDR_W'(ad);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_cmp++;
        if (rd_data !== exp_rd) begin
            n_bad++;
            $display("FAIL %s: rd_data actual %h expected %h", tag, rd_data, exp_rd);
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rdreg(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, MY_ADDR, tag);
    endtask

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R11 reset");
        cyc(1, 0, 0, 0, 0, 0, 1, MY_ADDR, "R11 reset read");
        rdreg("R8 constant bits");
        idle("R9 idle zero");
        // R1 / R3: fault latches, read shows it, next read clear
        cyc(0, 1, 0, 0, 0, 0, 0, 0, "R1 fault pulse");
        idle("R1 hold");
        idle("R1 hold");
        rdreg("R3 read shows fault");
        rdreg("R3 fault cleared");
        // R2 / R5: code words
        cyc(0, 0, 1, 1, 0, 0, 0, 0, "R2 page np=1");
        rdreg("R5 np one");
        rdreg("R2 page cleared");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R5 page np=0");
        rdreg("R5 np zero");
        // R4: collisions with read
        cyc(0, 1, 0, 0, 0, 0, 1, MY_ADDR, "R4 fault with read");
        rdreg("R4 fault kept");
        rdreg("R4 fault cleared");
        cyc(0, 0, 1, 1, 0, 0, 1, MY_ADDR, "R4 page with read");
        rdreg("R4 page kept");
        // R10: other addresses
        cyc(0, 1, 0, 0, 0, 0, 0, 0, "R10 set fault");
        cyc(0, 0, 0, 0, 0, 0, 1, 7, "R10 read other addr");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R10 read addr zero");
        rdreg("R10 fault still set");
        // R6 / R7: partner flags
        rdreg("R6 an zero before bursts");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R6 bursts");
        idle("R6 hold");
        rdreg("R6 an one");
        rdreg("R6 an stays");
        cyc(0, 1, 1, 1, 1, 1, 0, 0, "R7 restart with sets");
        rdreg("R7 bits 0 3 cleared 1 4 kept");
        cyc(0, 0, 1, 1, 1, 0, 0, 0, "R7 set again");
        cyc(0, 0, 0, 0, 0, 1, 1, MY_ADDR, "R7 restart during read");
        rdreg("R7 after restart");
        // R11: reset mid-run
        cyc(0, 1, 1, 1, 1, 0, 0, 0, "R11 set all");
        cyc(1, 0, 0, 0, 0, 0, 1, MY_ADDR, "R11 reset wins");
        rdreg("R11 all cleared");
        // mixed pattern
        for (int i = 0; i < 40; i++)
            cyc(0, (i % 7) == 0, (i % 5) == 1, (i % 3) == 0, (i % 11) == 2,
                (i % 13) == 4, (i % 2) == 0, ((i % 4) == 2) ? 3 : MY_ADDR, "R9 mixed");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule